// File: doc/BRIEF.md
# PCI Bus Bring-Up Sequencer

This block takes an external PCI bus out of reset for a host bridge. After a one-cycle start request it enables the output drivers for the bus clock and the bus reset line. It then starts the bus clock and holds reset for a minimum time. Next it releases reset and gives bus ownership to the internal arbiter, waits a short hold, and then waits a long settle period. Only after that does it raise a ready flag. Downstream logic, such as address window setup and interrupt unmasking, waits for that flag.

Every delay is a whole number of cycles. It is computed from a clock-frequency parameter in MHz and a time in microseconds for each phase. A simulation can therefore lower the frequency and shorten the runs. A synchronous reset returns the block to idle from any state, with every output low. A start request is only accepted in idle.

The controller has six states: `ST_IDLE`, `ST_DRIVE`, `ST_CLOCK`, `ST_ARB`, `ST_SETTLE` and `ST_READY`. It has these transitions:
- **accept**: `ST_IDLE`→`ST_DRIVE` when `start` is high.
- **clock-up**: `ST_DRIVE`→`ST_CLOCK`, always after one cycle.
- **release**: `ST_CLOCK`→`ST_ARB` when the reset-hold count expires.
- **hold-done**: `ST_ARB`→`ST_SETTLE` when the arbiter-hold count expires.
- **settled**: `ST_SETTLE`→`ST_READY` when the settle count expires.
- **abort**: any state→`ST_IDLE` on `srst`.

`ST_READY` holds until `srst`.

Top module: `pci_bus_bringup`

## Requirements
- R1: While `srst` is high and after it, with no start, all six outputs (`pci_clk_oe`, `pci_rst_oe`, `pci_clk_en`, `pci_rst_n`, `arb_internal`, `bus_ready`) are 0.
- R2: A `start` sampled high in idle at clock edge k gives, after edge k, `pci_clk_oe`=1, `pci_rst_oe`=1, `pci_clk_en`=0, `pci_rst_n`=0, `arb_internal`=0, `bus_ready`=0 for exactly one cycle.
- R3: The bus clock then runs with reset held low for exactly RST_CYC = CLK_FREQ_MHZ*RST_HOLD_US cycles (minimum 1): `pci_clk_en`=1, `pci_rst_n`=0, both driver enables 1, `arb_internal`=0.
- R4: Reset is then released (`pci_rst_n`=1) in the same cycle that `arb_internal` goes to 1. Both stay in that state for ARB_CYC = CLK_FREQ_MHZ*ARB_HOLD_US cycles (minimum 1) before the settle phase.
- R5: During the settle phase of SETTLE_CYC = CLK_FREQ_MHZ*SETTLE_US cycles (minimum 1), the outputs stay as in R4 and `bus_ready` stays 0.
- R6: `bus_ready` goes to 1 exactly 1+RST_CYC+ARB_CYC+SETTLE_CYC cycles after edge k. It then stays 1 with the other outputs unchanged until `srst`.
- R7: A `start` pulse or a held `start` in any state other than idle, including ready, has no effect on the outputs or their timing.
- R8: `srst` sampled high in any state makes all six outputs 0 after that edge, even if `start` is also high.
- R9: `pci_clk_en` is never 1 unless both driver enables are 1, and `pci_rst_n` is never 1 unless `pci_clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| srst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin the bring-up sequence |
| pci_clk_oe | output | 1 | Output driver enable for the bus clock pin |
| pci_rst_oe | output | 1 | Output driver enable for the bus reset pin |
| pci_clk_en | output | 1 | Bus clock running |
| pci_rst_n | output | 1 | Bus reset, active low |
| arb_internal | output | 1 | Bus arbitration handled by the internal arbiter |
| bus_ready | output | 1 | Bus may now be used by later setup logic |

## Verification
The bench compares every cycle of each sequence with the phase boundaries it expects. An off-by-one in any delay counter is caught: the reset release, the arbiter handover or the ready flag would move by one cycle. It sends extra start pulses, and holds start high, while a sequence is running and after ready. A design that restarted on these would drop the clock or pull reset low again in the middle of the run. It also aborts with `srst` in the drive, clock and settle phases, with `start` high at the same time. A design that gave start priority, or that left a phase counter loaded, would show outputs that are not zero, or a next run that is too short.

// File: rtl/bringup_pkg.sv
`timescale 1ns/1ps
package bringup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRIVE  = 3'd1,
        ST_CLOCK  = 3'd2,
        ST_ARB    = 3'd3,
        ST_SETTLE = 3'd4,
        ST_READY  = 3'd5
    } bup_state_e;

    typedef struct packed {
        logic clk_oe;
        logic rst_oe;
        logic clk_en;
        logic rst_n;
        logic arb_int;
        logic ready;
    } bup_out_t;

    localparam bup_out_t BUP_OUT_OFF = '0;

    function automatic int unsigned cyc_of(input int unsigned mhz, input int unsigned usec);
        int unsigned c;
        c = mhz * usec;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bup_delay_cnt.sv
`timescale 1ns/1ps
module bup_delay_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // An expired count stays expired until reloaded
    AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (srst)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/bup_out_reg.sv
`timescale 1ns/1ps
module bup_out_reg
    import bringup_pkg::*;
(
    input  logic       clk,
    input  logic       srst,
    input  bup_state_e nxt_state,
    output bup_out_t   outs
);
    bup_out_t dec;

    always_comb begin
        dec = BUP_OUT_OFF;
        unique case (nxt_state)
            ST_IDLE: dec = BUP_OUT_OFF;
            ST_DRIVE: begin
                dec.clk_oe = 1'b1;
                dec.rst_oe = 1'b1;
            end
            ST_CLOCK: begin
                dec.clk_oe = 1'b1;
                dec.rst_oe = 1'b1;
                dec.clk_en = 1'b1;
            end
            ST_ARB, ST_SETTLE: begin
                dec.clk_oe  = 1'b1;
                dec.rst_oe  = 1'b1;
                dec.clk_en  = 1'b1;
                dec.rst_n   = 1'b1;
                dec.arb_int = 1'b1;
            end
            ST_READY: begin
                dec.clk_oe  = 1'b1;
                dec.rst_oe  = 1'b1;
                dec.clk_en  = 1'b1;
                dec.rst_n   = 1'b1;
                dec.arb_int = 1'b1;
                dec.ready   = 1'b1;
            end
            default: dec = BUP_OUT_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) outs <= BUP_OUT_OFF;
        else      outs <= dec;
    end

endmodule

// File: rtl/pci_bus_bringup.sv
`timescale 1ns/1ps
module pci_bus_bringup
    import bringup_pkg::*;
#(
    parameter int unsigned CLK_FREQ_MHZ = 100,
    parameter int unsigned RST_HOLD_US  = 150,
    parameter int unsigned ARB_HOLD_US  = 1,
    parameter int unsigned SETTLE_US    = 10000
) (
    input  logic clk,
    input  logic srst,
    input  logic start,
    output logic pci_clk_oe,
    output logic pci_rst_oe,
    output logic pci_clk_en,
    output logic pci_rst_n,
    output logic arb_internal,
    output logic bus_ready
);
    localparam int unsigned RST_CYC    = cyc_of(CLK_FREQ_MHZ, RST_HOLD_US);
    localparam int unsigned ARB_CYC    = cyc_of(CLK_FREQ_MHZ, ARB_HOLD_US);
    localparam int unsigned SETTLE_CYC = cyc_of(CLK_FREQ_MHZ, SETTLE_US);
    localparam int unsigned MAX_CYC    = max3(RST_CYC, ARB_CYC, SETTLE_CYC);
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] ARB_LOAD    = CNT_W'(ARB_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

    bup_state_e       state_q, state_d;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    bup_out_t         outs;

    // Next-state and counter-load decisions
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                state_d  = ST_CLOCK;
                cnt_load = 1'b1;
                cnt_val  = RST_LOAD;
            end
            ST_CLOCK: begin
                if (cnt_done) begin
                    state_d  = ST_ARB;
                    cnt_load = 1'b1;
                    cnt_val  = ARB_LOAD;
                end
            end
            ST_ARB: begin
                if (cnt_done) begin
                    state_d  = ST_SETTLE;
                    cnt_load = 1'b1;
                    cnt_val  = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (cnt_done) state_d = ST_READY;
            end
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (srst) state_q <= ST_IDLE;
        else      state_q <= state_d;
    end

    bup_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .srst     (srst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    // Output register, aligned with the state register
    bup_out_reg u_out (
        .clk       (clk),
        .srst      (srst),
        .nxt_state (state_d),
        .outs      (outs)
    );

    assign pci_clk_oe   = outs.clk_oe;
    assign pci_rst_oe   = outs.rst_oe;
    assign pci_clk_en   = outs.clk_en;
    assign pci_rst_n    = outs.rst_n;
    assign arb_internal = outs.arb_int;
    assign bus_ready    = outs.ready;

    AST_CLK_NEEDS_DRIVERS: assert property (@(posedge clk) disable iff (srst)
        pci_clk_en |-> (pci_clk_oe && pci_rst_oe)); // R9
    AST_RELEASE_NEEDS_CLK: assert property (@(posedge clk) disable iff (srst)
        pci_rst_n |-> pci_clk_en); // R9
    AST_RELEASE_AFTER_CLK: assert property (@(posedge clk) disable iff (srst)
        $rose(pci_rst_n) |-> ($past(pci_clk_en) && arb_internal)); // R4
    AST_READY_AFTER_ARB: assert property (@(posedge clk) disable iff (srst)
        $rose(bus_ready) |-> $past(arb_internal)); // R6
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (srst)
        bus_ready |=> bus_ready); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (srst)
        (state_q != ST_IDLE) |=> (state_q != ST_DRIVE)); // R7
    AST_SRST_CLEARS: assert property (@(posedge clk)
        srst |=> (!pci_clk_oe && !pci_rst_oe && !pci_clk_en && !pci_rst_n
                  && !arb_internal && !bus_ready)); // R8

endmodule

// File: tb/pci_bus_bringup_tb.sv
`timescale 1ns/1ps
module pci_bus_bringup_tb;
    localparam int MHZ  = 2;
    localparam int RUS  = 150;
    localparam int AUS  = 1;
    localparam int SUS  = 2000;
    localparam int NR   = MHZ * RUS;
    localparam int NA   = MHZ * AUS;
    localparam int NS   = MHZ * SUS;
    localparam int TOT  = 1 + NR + NA + NS;

    logic clk = 1'b0;
    logic srst, start;
    logic pci_clk_oe, pci_rst_oe, pci_clk_en, pci_rst_n, arb_internal, bus_ready;
    int   n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    pci_bus_bringup #(
        .CLK_FREQ_MHZ(MHZ), .RST_HOLD_US(RUS), .ARB_HOLD_US(AUS), .SETTLE_US(SUS)
    ) u_dut (
        .clk(clk), .srst(srst), .start(start),
        .pci_clk_oe(pci_clk_oe), .pci_rst_oe(pci_rst_oe), .pci_clk_en(pci_clk_en),
        .pci_rst_n(pci_rst_n), .arb_internal(arb_internal), .bus_ready(bus_ready)
    );

    // Expected output vector {clk_oe, rst_oe, clk_en, rst_n, arb, ready}, t edges after accept
    function automatic logic [5:0] exp_vec(input int t);
        if (t < 0)                 return 6'b000000;
        if (t == 0)                return 6'b110000;
        if (t <= NR)               return 6'b111000;
        if (t <= NR + NA + NS)     return 6'b111110;
        return 6'b111111;
    endfunction

    function automatic string req_of(input int t);
        if (t < 0)             return "R1";
        if (t == 0)            return "R2";
        if (t <= NR)           return "R3";
        if (t <= NR + NA)      return "R4";
        if (t <= NR + NA + NS) return "R5";
        return "R6";
    endfunction

    function automatic logic [5:0] act_vec();
        return {pci_clk_oe, pci_rst_oe, pci_clk_en, pci_rst_n, arb_internal, bus_ready};
    endfunction

    task automatic chk(input logic [5:0] exp, input string req);
        n_chk++;
        if (act_vec() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b at cycle %0d", req, act_vec(), exp, cyc);
        end
        // R9 ordering invariant
        n_chk++;
        if ((pci_clk_en && !(pci_clk_oe && pci_rst_oe)) || (pci_rst_n && !pci_clk_en)) begin
            n_fail++;
            $display("FAIL R9: outputs %b expected ordered enables at cycle %0d", act_vec(), cyc);
        end
    endtask

    // mode: 0 none, 1 random start pulses, 2 start held high (R7)
    task automatic run(input int abort_at, input int mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= TOT + 3; t++) begin
            chk(exp_vec(t), (mode != 0) ? {req_of(t), " R7"} : req_of(t));
            if (t == abort_at) break;
            if (mode == 1)      start = (($urandom % 6) == 0);
            else if (mode == 2) start = 1'b1;
            @(negedge clk);
        end
        // R8: srst wins even with start high
        srst  = 1'b1;
        start = 1'b1;
        @(negedge clk);
        chk(6'b000000, "R8");
        srst  = 1'b0;
        start = 1'b0;
        @(negedge clk);
        chk(6'b000000, "R1");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycle %0d expected end before 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        srst  = 1'b1;
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk(6'b000000, "R8");
        srst  = 1'b0;
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(6'b000000, "R1");
        end
        run(-1, 0);                                   // full sequence
        run(-1, 1);                                   // random ignored starts
        run(0, 0);                                    // abort in drive phase
        run(1 + ($urandom % NR), 1);                  // abort in clock phase
        run(NR + NA + 1 + ($urandom % NS), 0);        // abort in settle phase
        run(-1, 2);                                   // start held high throughout
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule